// File: doc/BRIEF.md
# Power-Fault Sleep Entry Sequencer

This block takes a processor subsystem into sleep. Sleep can start in two ways: software writes the sleep code into the mode register, or a supply-fault or battery-fault input goes low. A control bit decides what a fault does. With the bit clear, the fault starts the shutdown sequence at once. With the bit set, the block first raises an abort request so that software can run a handler. That handler then requests sleep through the mode register.

The shutdown always runs the same stages in the same order. First the CPU pipeline drains. Next the memory controller flushes its outstanding work, and new display and DMA traffic is blocked from that point on. Then the SDRAM enters self-refresh. Last, the GPIO outputs switch to values that software loaded in advance. After that the block stays asleep until reset, which also stands in for wake-up.

A sleep that software requested can be cancelled by an interrupt during the drain or flush stage. A sleep that a fault started cannot be cancelled. Both fault inputs set one shared sticky status bit, and that bit does not record which fault it was.

Top module: `pwr_sleep_seq`

## Requirements
- R1: After reset every request output, `abort_req`, `periph_block` and `sleep_active` are 0. Register reads return 0. `gpio_out` equals `gpio_run`.
- R2: A write to address 1 with bits [1:0] = 2'b11 starts the sequence from run. `cpu_drain_req` rises after the clock edge that takes the write. A write of any other mode code starts nothing.
- R3: The requests come in a fixed order, and at most one is high at any time. `cpu_drain_req` stays high until `cpu_drain_ack`. Then `mc_flush_req` stays high until `mc_flush_done`. Then `sdram_sr_req` stays high until `sdram_sr_ack`. After that comes one GPIO switch cycle, and then `sleep_active` rises.
- R4: `periph_block` is high from the first cycle of `mc_flush_req` through sleep.
- R5: The sleep GPIO registers are bank 0 at address 4, bank 1 at address 5 and bank 2 at address 6. Bank 0 drives bits [31:0] of `gpio_out`. Until the GPIO switch step, `gpio_out` follows `gpio_run`. From that step on, it shows the bank values.
- R6: Once `sleep_active` is high, it stays high until reset.
- R7: An `irq` during the drain or flush stage of a software-requested sleep drops all requests and returns the block to run.
- R8: With the abort-enable bit (address 0, bit 0) clear, a fault starts the sequence with no `abort_req`. A fault that arrives during a software-requested sequence makes that sequence uncancellable. In either case `irq` has no effect.
- R9: With the abort-enable bit set, a fault raises a one-cycle `abort_req` and starts no sequence. Each later fault raises the pulse again, and `irq` does nothing. A sleep write made after the abort runs a sequence that `irq` cannot cancel.
- R10: The status bit (address 2, bit 0) is set by a fault on either input or on both. Only reset clears it. A fault held low counts once, and two faults falling together give one event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| fault_vdd_n | input | 1 | Supply fault, active low, asynchronous |
| fault_batt_n | input | 1 | Battery fault, active low, asynchronous |
| irq | input | 1 | Interrupt |
| abort_req | output | 1 | One-cycle imprecise abort request to the CPU |
| cpu_drain_req | output | 1 | Request to drain the CPU pipeline |
| cpu_drain_ack | input | 1 | Pipeline drained |
| mc_flush_req | output | 1 | Request to the memory controller to finish outstanding work |
| mc_flush_done | input | 1 | Memory controller flushed |
| periph_block | output | 1 | Blocks new display and DMA transactions |
| sdram_sr_req | output | 1 | Command for SDRAM self-refresh |
| sdram_sr_ack | input | 1 | SDRAM is in self-refresh |
| gpio_run | input | 96 | GPIO values during normal running |
| gpio_out | output | 96 | GPIO pin values |
| sleep_active | output | 1 | Sleep reached |

## Verification
The sequence is run from each of its trigger patterns: a software sleep write, a supply fault with the abort bit clear, a battery fault with the abort bit set, and both faults falling together. These runs separate the immediate path from the abort path, and show that two coincident faults give one event. An interrupt is sent during the flush stage of a software sleep and during the drain stage of each fault-driven sleep, which shows which kinds of entry can be cancelled. The GPIO outputs are compared just before and just after the switch step, and a fault is held low and then repeated to test edge detection and the re-raised abort.

// File: rtl/pwr_sleep_pkg.sv
package pwr_sleep_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_ABORT_WAIT,
        ST_DRAIN,
        ST_FLUSH,
        ST_SELFREF,
        ST_GPIO_SW,
        ST_SLEEP
    } seq_state_t;

    typedef struct packed {
        logic drain;
        logic flush;
        logic selfref;
    } seq_req_t;

    localparam int ADDR_W = 3;
    localparam int MODE_W = 2;

    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_MODE  = 3'd1;
    localparam logic [ADDR_W-1:0] A_STAT  = 3'd2;
    localparam logic [ADDR_W-1:0] A_BANK0 = 3'd4;

    localparam logic [MODE_W-1:0] MODE_SLEEP = 2'b11;

    // Only the stages before self-refresh may be backed out by an interrupt.
    function automatic logic stage_cancellable(seq_state_t s);
        return (s == ST_DRAIN) || (s == ST_FLUSH);
    endfunction

    function automatic logic stage_blocks_periph(seq_state_t s);
        return (s == ST_FLUSH) || (s == ST_SELFREF) ||
               (s == ST_GPIO_SW) || (s == ST_SLEEP);
    endfunction

endpackage

// File: rtl/pwr_fault_detect.sv
module pwr_fault_detect #(
    parameter int NUM  = 2,
    parameter int SYNC = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NUM-1:0] fault_n,
    output logic           evt
);
    logic [NUM-1:0] fell;

    generate
        for (genvar g = 0; g < NUM; g++) begin : g_ch
            logic [SYNC-1:0] sh_q;
            logic            last_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    sh_q   <= '1;
                    last_q <= 1'b1;
                end else begin
                    sh_q   <= {sh_q[SYNC-2:0], fault_n[g]};
                    last_q <= sh_q[SYNC-1];
                end
            end
            assign fell[g] = last_q & ~sh_q[SYNC-1];
        end
    endgenerate

    assign evt = |fell;
endmodule

// File: rtl/pwr_sleep_regs.sv
module pwr_sleep_regs
    import pwr_sleep_pkg::*;
#(
    parameter int GPIO_W = 32,
    parameter int BANKS  = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [GPIO_W-1:0]       wdata,
    input  logic                    fault_evt,
    output logic                    abort_en,
    output logic                    sleep_cmd,
    output logic                    fault_seen,
    output logic [BANKS*GPIO_W-1:0] bank_flat,
    output logic [GPIO_W-1:0]       rdata
);
    logic [GPIO_W-1:0] bank_q [BANKS];
    logic [MODE_W-1:0] mode_q;
    logic              abort_en_q;
    logic              seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            abort_en_q <= 1'b0;
            mode_q     <= '0;
            seen_q     <= 1'b0;
            for (int i = 0; i < BANKS; i++) bank_q[i] <= '0;
        end else begin
            if (fault_evt) seen_q <= 1'b1;
            if (wr) begin
                if (addr == A_CTRL) abort_en_q <= wdata[0];
                if (addr == A_MODE) mode_q <= wdata[MODE_W-1:0];
                for (int i = 0; i < BANKS; i++)
                    if (addr == A_BANK0 + ADDR_W'(i)) bank_q[i] <= wdata;
            end
        end
    end

    assign sleep_cmd  = wr && (addr == A_MODE) && (wdata[MODE_W-1:0] == MODE_SLEEP);
    assign abort_en   = abort_en_q;
    assign fault_seen = seen_q;

    generate
        for (genvar g = 0; g < BANKS; g++) begin : g_flat
            assign bank_flat[g*GPIO_W +: GPIO_W] = bank_q[g];
        end
    endgenerate

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL:  rdata[0] = abort_en_q;
            A_MODE:  rdata[MODE_W-1:0] = mode_q;
            A_STAT:  rdata[0] = seen_q;
            default: begin
                for (int i = 0; i < BANKS; i++)
                    if (addr == A_BANK0 + ADDR_W'(i)) rdata = bank_q[i];
            end
        endcase
    end
endmodule

// File: rtl/pwr_sleep_fsm.sv
module pwr_sleep_fsm
    import pwr_sleep_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     fault_evt,
    input  logic     abort_en,
    input  logic     sleep_cmd,
    input  logic     irq,
    input  logic     drain_ack,
    input  logic     flush_done,
    input  logic     sr_ack,
    output seq_req_t req,
    output logic     abort_req,
    output logic     periph_block,
    output logic     gpio_apply,
    output logic     sleep_active
);
    seq_state_t state_q, state_d;
    logic forced_q, forced_d;
    logic abort_q, abort_d;
    logic apply_q, apply_d;

    always_comb begin
        state_d  = state_q;
        forced_d = forced_q;
        abort_d  = 1'b0;
        apply_d  = apply_q;
        case (state_q)
            ST_RUN: begin
                if (fault_evt) begin
                    if (abort_en) begin
                        state_d = ST_ABORT_WAIT;
                        abort_d = 1'b1;
                    end else begin
                        state_d  = ST_DRAIN;
                        forced_d = 1'b1;
                    end
                end else if (sleep_cmd) begin
                    state_d  = ST_DRAIN;
                    forced_d = 1'b0;
                end
            end
            ST_ABORT_WAIT: begin
                if (fault_evt) begin
                    abort_d = 1'b1;
                end else if (sleep_cmd) begin
                    state_d  = ST_DRAIN;
                    forced_d = 1'b1;
                end
            end
            ST_DRAIN, ST_FLUSH: begin
                if (fault_evt) forced_d = 1'b1;
                if (irq && !forced_q && !fault_evt) begin
                    state_d = ST_RUN;
                end else if (state_q == ST_DRAIN && drain_ack) begin
                    state_d = ST_FLUSH;
                end else if (state_q == ST_FLUSH && flush_done) begin
                    state_d = ST_SELFREF;
                end
            end
            ST_SELFREF: if (sr_ack) state_d = ST_GPIO_SW;
            ST_GPIO_SW: begin
                apply_d = 1'b1;
                state_d = ST_SLEEP;
            end
            ST_SLEEP: state_d = ST_SLEEP;
            default:  state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_RUN;
            forced_q <= 1'b0;
            abort_q  <= 1'b0;
            apply_q  <= 1'b0;
        end else begin
            state_q  <= state_d;
            forced_q <= forced_d;
            abort_q  <= abort_d;
            apply_q  <= apply_d;
        end
    end

    assign req.drain    = (state_q == ST_DRAIN);
    assign req.flush    = (state_q == ST_FLUSH);
    assign req.selfref  = (state_q == ST_SELFREF);
    assign abort_req    = abort_q;
    assign periph_block = stage_blocks_periph(state_q);
    assign gpio_apply   = apply_q;
    assign sleep_active = (state_q == ST_SLEEP);

    logic unused_cancel;
    assign unused_cancel = stage_cancellable(state_q);
endmodule

// File: rtl/pwr_sleep_seq.sv
module pwr_sleep_seq
    import pwr_sleep_pkg::*;
#(
    parameter int GPIO_W = 32,
    parameter int BANKS  = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    reg_wr,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic [GPIO_W-1:0]       reg_wdata,
    output logic [GPIO_W-1:0]       reg_rdata,
    input  logic                    fault_vdd_n,
    input  logic                    fault_batt_n,
    input  logic                    irq,
    output logic                    abort_req,
    output logic                    cpu_drain_req,
    input  logic                    cpu_drain_ack,
    output logic                    mc_flush_req,
    input  logic                    mc_flush_done,
    output logic                    periph_block,
    output logic                    sdram_sr_req,
    input  logic                    sdram_sr_ack,
    input  logic [BANKS*GPIO_W-1:0] gpio_run,
    output logic [BANKS*GPIO_W-1:0] gpio_out,
    output logic                    sleep_active
);
    localparam int NUM_FAULTS = 2;

    logic                    fault_evt;
    logic                    abort_en;
    logic                    sleep_cmd;
    logic                    fault_seen;
    logic                    gpio_apply;
    logic [BANKS*GPIO_W-1:0] bank_flat;
    seq_req_t                req;

    pwr_fault_detect #(.NUM(NUM_FAULTS), .SYNC(2)) u_fault (
        .clk     (clk),
        .rst     (rst),
        .fault_n ({fault_batt_n, fault_vdd_n}),
        .evt     (fault_evt)
    );

    pwr_sleep_regs #(.GPIO_W(GPIO_W), .BANKS(BANKS)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr         (reg_wr),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .fault_evt  (fault_evt),
        .abort_en   (abort_en),
        .sleep_cmd  (sleep_cmd),
        .fault_seen (fault_seen),
        .bank_flat  (bank_flat),
        .rdata      (reg_rdata)
    );

    pwr_sleep_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .fault_evt    (fault_evt),
        .abort_en     (abort_en),
        .sleep_cmd    (sleep_cmd),
        .irq          (irq),
        .drain_ack    (cpu_drain_ack),
        .flush_done   (mc_flush_done),
        .sr_ack       (sdram_sr_ack),
        .req          (req),
        .abort_req    (abort_req),
        .periph_block (periph_block),
        .gpio_apply   (gpio_apply),
        .sleep_active (sleep_active)
    );

    assign cpu_drain_req = req.drain;
    assign mc_flush_req  = req.flush;
    assign sdram_sr_req  = req.selfref;
    assign gpio_out      = gpio_apply ? bank_flat : gpio_run;
endmodule

// File: rtl/pwr_sleep_seq_chk.sv
module pwr_sleep_seq_chk (
    input logic clk,
    input logic rst,
    input logic abort_req,
    input logic abort_en,
    input logic fault_seen,
    input logic cpu_drain_req,
    input logic cpu_drain_ack,
    input logic mc_flush_req,
    input logic mc_flush_done,
    input logic sdram_sr_req,
    input logic periph_block,
    input logic sleep_active
);
    assert_abort_gated_R9: assert property (@(posedge clk) disable iff (rst)
        abort_req |-> abort_en);

    assert_one_request_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cpu_drain_req, mc_flush_req, sdram_sr_req}));

    assert_flush_after_drain_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(mc_flush_req) |-> $past(cpu_drain_ack));

    assert_selfref_after_flush_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(sdram_sr_req) |-> $past(mc_flush_done));

    assert_periph_blocked_R4: assert property (@(posedge clk) disable iff (rst)
        (mc_flush_req || sdram_sr_req || sleep_active) |-> periph_block);

    assert_sleep_holds_R6: assert property (@(posedge clk) disable iff (rst)
        sleep_active |=> sleep_active);

    assert_status_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        fault_seen |=> fault_seen);

    assert_abort_has_fault_R10: assert property (@(posedge clk) disable iff (rst)
        abort_req |-> fault_seen);
endmodule

bind pwr_sleep_seq pwr_sleep_seq_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .abort_req     (abort_req),
    .abort_en      (abort_en),
    .fault_seen    (fault_seen),
    .cpu_drain_req (cpu_drain_req),
    .cpu_drain_ack (cpu_drain_ack),
    .mc_flush_req  (mc_flush_req),
    .mc_flush_done (mc_flush_done),
    .sdram_sr_req  (sdram_sr_req),
    .periph_block  (periph_block),
    .sleep_active  (sleep_active)
);

// File: tb/pwr_sleep_seq_test.sv
`timescale 1ns/1ps
module pwr_sleep_seq_test;
    typedef enum {EV_ABORT, EV_DRAIN, EV_FLUSH, EV_SELFREF, EV_SLEEP} ev_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        fault_vdd_n = 1'b1, fault_batt_n = 1'b1, irq = 1'b0;
    logic        abort_req, cpu_drain_req, mc_flush_req, sdram_sr_req;
    logic        periph_block, sleep_active;
    logic        cpu_drain_ack = 1'b0, mc_flush_done = 1'b0, sdram_sr_ack = 1'b0;
    logic [95:0] gpio_run = 96'h0F0F_1234_5555_AAAA_CAFE_0001;
    logic [95:0] gpio_out;

    localparam logic [31:0] SB0 = 32'hA5A5_0001;
    localparam logic [31:0] SB1 = 32'h5A5A_0002;
    localparam logic [31:0] SB2 = 32'h0000_FFF3;

    int   n_chk = 0, n_fail = 0;
    bit   done = 0;
    ev_t  exp_q[$];
    logic p_ab = 0, p_dr = 0, p_fl = 0, p_sr = 0, p_sl = 0;

    always #10 clk = ~clk;

    pwr_sleep_seq uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .fault_vdd_n(fault_vdd_n), .fault_batt_n(fault_batt_n), .irq(irq),
        .abort_req(abort_req), .cpu_drain_req(cpu_drain_req),
        .cpu_drain_ack(cpu_drain_ack), .mc_flush_req(mc_flush_req),
        .mc_flush_done(mc_flush_done), .periph_block(periph_block),
        .sdram_sr_req(sdram_sr_req), .sdram_sr_ack(sdram_sr_ack),
        .gpio_run(gpio_run), .gpio_out(gpio_out), .sleep_active(sleep_active)
    );

    task automatic check(input bit ok, input string req, input logic [95:0] act,
                         input logic [95:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: every rising event is matched against the scoreboard queue.
    task automatic see(input ev_t e);
        if (exp_q.size() == 0) begin
            check(0, "R3 unexpected event", 96'(e), 96'hFF);
        end else begin
            ev_t x = exp_q.pop_front();
            check(x == e, "R3 event order", 96'(e), 96'(x));
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (abort_req && !p_ab)     see(EV_ABORT);
            if (cpu_drain_req && !p_dr) see(EV_DRAIN);
            if (mc_flush_req && !p_fl)  see(EV_FLUSH);
            if (sdram_sr_req && !p_sr)  see(EV_SELFREF);
            if (sleep_active && !p_sl)  see(EV_SLEEP);
        end
        p_ab = abort_req; p_dr = cpu_drain_req; p_fl = mc_flush_req;
        p_sr = sdram_sr_req; p_sl = sleep_active;
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1;
        fault_vdd_n = 1; fault_batt_n = 1; irq = 0;
        cpu_drain_ack = 0; mc_flush_done = 0; sdram_sr_ack = 0;
        check(exp_q.size() == 0, "R3 all expected events seen", 96'(exp_q.size()), 0);
        exp_q.delete();
        cyc(3); rst = 0;
    endtask

    task automatic ack_drain();
        @(negedge clk); cpu_drain_ack = 1; @(negedge clk); cpu_drain_ack = 0;
    endtask
    task automatic ack_flush();
        @(negedge clk); mc_flush_done = 1; @(negedge clk); mc_flush_done = 0;
    endtask
    task automatic ack_sr();
        @(negedge clk); sdram_sr_ack = 1; @(negedge clk); sdram_sr_ack = 0;
    endtask
    task automatic pulse_irq();
        @(negedge clk); irq = 1; @(negedge clk); irq = 0;
    endtask

    task automatic finish_seq();
        exp_q.push_back(EV_FLUSH);
        ack_drain(); cyc(1);
        check(periph_block == 1, "R4 block during flush", 96'(periph_block), 1);
        exp_q.push_back(EV_SELFREF);
        ack_flush(); cyc(1);
        check(gpio_out == gpio_run, "R5 gpio before switch", gpio_out, gpio_run);
        exp_q.push_back(EV_SLEEP);
        ack_sr(); cyc(3);
        check(sleep_active == 1, "R3 sleep reached", 96'(sleep_active), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        cyc(3); rst = 0;
        // R1 reset state
        cyc(1);
        check({abort_req, cpu_drain_req, mc_flush_req, sdram_sr_req, periph_block, sleep_active} == 0,
              "R1 outputs idle", 96'({abort_req, cpu_drain_req, mc_flush_req, sdram_sr_req, periph_block, sleep_active}), 0);
        check(gpio_out == gpio_run, "R1 gpio follows run", gpio_out, gpio_run);
        rd(3'd2, d); check(d == 0, "R1 status clear", 96'(d), 0);
        rd(3'd4, d); check(d == 0, "R1 bank clear", 96'(d), 0);

        // R2/R5/R6: software sleep to completion
        wr(3'd4, SB0); wr(3'd5, SB1); wr(3'd6, SB2);
        rd(3'd5, d); check(d == SB1, "R5 bank readback", 96'(d), 96'(SB1));
        wr(3'd1, 32'h1); cyc(2);
        check(cpu_drain_req == 0, "R2 other mode code ignored", 96'(cpu_drain_req), 0);
        exp_q.push_back(EV_DRAIN);
        wr(3'd1, 32'h3); cyc(1);
        check(cpu_drain_req == 1, "R2 sleep write drains", 96'(cpu_drain_req), 1);
        finish_seq();
        check(gpio_out == {SB2, SB1, SB0}, "R5 gpio sleep values", gpio_out, {SB2, SB1, SB0});
        pulse_irq(); cyc(3);
        check(sleep_active == 1, "R6 sleep held", 96'(sleep_active), 1);

        // R7: interrupt cancels software sleep in flush
        do_reset();
        exp_q.push_back(EV_DRAIN);
        wr(3'd1, 32'h3); cyc(1);
        exp_q.push_back(EV_FLUSH);
        ack_drain(); cyc(1);
        pulse_irq(); cyc(1);
        check({cpu_drain_req, mc_flush_req, sdram_sr_req, periph_block} == 0, "R7 cancel drops requests",
              96'({cpu_drain_req, mc_flush_req, sdram_sr_req, periph_block}), 0);
        exp_q.push_back(EV_DRAIN);
        wr(3'd1, 32'h3); cyc(1);
        check(cpu_drain_req == 1, "R7 back in run", 96'(cpu_drain_req), 1);

        // R8: supply fault with abort disabled, held low
        do_reset();
        exp_q.push_back(EV_DRAIN);
        @(negedge clk); fault_vdd_n = 0;
        cyc(5);
        check(cpu_drain_req == 1 && abort_req == 0, "R8 fault drains without abort",
              96'({cpu_drain_req, abort_req}), 96'b10);
        rd(3'd2, d); check(d[0] == 1, "R10 status by supply fault", 96'(d[0]), 1);
        pulse_irq(); cyc(2);
        check(cpu_drain_req == 1, "R8 irq ignored in fault sleep", 96'(cpu_drain_req), 1);
        finish_seq();

        // R9: battery fault with abort enabled
        do_reset();
        wr(3'd0, 32'h1);
        exp_q.push_back(EV_ABORT);
        @(negedge clk); fault_batt_n = 0;
        cyc(6);
        check(cpu_drain_req == 0 && abort_req == 0, "R9 abort is a pulse, no drain",
              96'({cpu_drain_req, abort_req}), 0);
        rd(3'd2, d); check(d[0] == 1, "R10 status by battery fault", 96'(d[0]), 1);
        pulse_irq(); cyc(2);
        @(negedge clk); fault_batt_n = 1; cyc(4);
        exp_q.push_back(EV_ABORT);
        @(negedge clk); fault_vdd_n = 0; cyc(6);
        check(exp_q.size() == 0, "R9 abort re-raised", 96'(exp_q.size()), 0);
        exp_q.push_back(EV_DRAIN);
        wr(3'd1, 32'h3); cyc(1);
        pulse_irq(); cyc(2);
        check(cpu_drain_req == 1, "R9 post-abort sleep not cancelled", 96'(cpu_drain_req), 1);
        finish_seq();

        // R10: both faults together, one event; only reset clears
        do_reset();
        rd(3'd2, d); check(d[0] == 0, "R10 reset clears status", 96'(d[0]), 0);
        wr(3'd0, 32'h1);
        exp_q.push_back(EV_ABORT);
        @(negedge clk); fault_vdd_n = 0; fault_batt_n = 0;
        cyc(10);
        check(exp_q.size() == 0, "R10 single abort for two faults", 96'(exp_q.size()), 0);
        rd(3'd2, d); check(d[0] == 1, "R10 status by both", 96'(d[0]), 1);

        do_reset();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule